// File: doc/BRIEF.md
# Static memory bank timing controller

This block sequences single-transfer requests from a host port onto an external static memory bus split across four chip-select banks. Every bank holds its own configuration word. The word sets the bank's access timing in clock cycles: the read length, the write strobe length, the shortened length of a subsequent burst-ROM read, and the idle turnaround before an access. It also holds the byte-lane level used during reads, a write-protect bit, a burst-ROM bit and the data width. The block drives one-hot active-low chip selects, active-low byte-lane selects, an active-low write enable, the address, write data with a drive enable, and it captures read data.

The host presents a request with `req_valid` and keeps it unchanged until `req_ready` pulses for one cycle. If the request was refused, `req_err` is high in that same cycle. Two address bits located at the bank-size boundary `BANK_LSB` choose the bank. The configuration words are loaded directly through one write strobe per bank. Each bank has two sticky error flags, one for write protection and one for oversize requests. A write-one clear per bank resets both flags of that bank.

Top module: `smc_bank_ctrl`

## Requirements
- R1: The bank index is `req_addr[BANK_LSB+1:BANK_LSB]`. During an access only that bank's `mem_cs_n` bit is low, and no other bank's chip select ever goes low.
- R2: A read that is not a subsequent burst read holds its bank's chip select low for exactly RW+3 cycles, where RW is the read wait field. The value on `mem_din` in the last of those cycles is returned on `req_rdata` together with the `req_ready` pulse.
- R3: A write runs in three phases. First comes one setup cycle with data driven (`mem_doe`=1) while chip select, byte-lane selects and write enable are all high. Next come WW+1 strobe cycles with chip select and write enable low and `mem_bls_n` = ~`req_be`, where WW is the write wait field. Last comes one hold cycle with chip select low and byte-lane selects and write enable high. `mem_dout` equals `req_wdata` throughout.
- R4: In a bank whose burst bit is set, a read counts as subsequent when it follows a completed read in the same bank, with no other request in between, at the previous address plus the bank width in bytes. The width codes are 00 = 1 byte, 01 = 2 bytes, and 10 or 11 = 4 bytes. A subsequent read holds chip select low for WW+1 cycles.
- R5: Turnaround applies when the previous access was in a different bank, or was in the same bank but in the other direction. In that case at least ID+1 cycles with every chip select high and `mem_doe` low come between the previous access and the new one, where ID is the new bank's idle field. In every other case a back-to-back request starts after exactly 2 such cycles.
- R6: During read cycles every `mem_bls_n` line is high when the bank's read lane bit is 0 and low when it is 1.
- R7: A write to a bank whose protect bit is set causes no bus activity and is answered by `req_ready` with `req_err` high. It also sets that bank's bit in `prot_err`. The bit stays set until a 1 is written to the bank's `err_clr` bit.
- R8: A request with `req_size` above 2 (more than 4 bytes) causes no bus activity and is answered with `req_err` high. It sets that bank's `size_err` bit, which `err_clr` clears in the same way.
- R9: The configuration word layout is: idle in [3:0], read wait in [8:4], write wait in [13:9], read lane in [14], protect in [15], burst in [16] and width in [18:17]. `cfg_we[i]` loads the word of bank i. At reset each word reads idle=15, both waits=31, read lane, protect and burst=0, and width=10. After reset all chip selects are high, write enable is high, no data is driven, and the ready and error outputs and all flags are 0.
- R10: `req_ready` is high for a single cycle per request. A new request is not accepted in the cycle in which `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 4 | Per-bank configuration load strobe |
| cfg_wdata | input | 19 | Configuration word to load |
| err_clr | input | 4 | Per-bank write-one clear of both error flags |
| prot_err | output | 4 | Sticky write-protect error per bank |
| size_err | output | 4 | Sticky oversize-request error per bank |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_size | input | 3 | log2 of the transfer size in bytes |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Request was refused (valid with req_ready) |
| req_rdata | output | 32 | Read data |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_bls_n | output | 4 | Active-low byte-lane selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | AW | Memory address |
| mem_dout | output | 32 | Write data to memory |
| mem_doe | output | 1 | Write data drive enable |
| mem_din | input | 32 | Read data from memory |

## Verification
The assertions rely on the host holding a request steady until `req_ready`, and on no configuration word changing while an access to its bank is under way. The write-protect and size flags are assumed to change only through a request or `err_clr`. The bench keeps to these conditions: it issues each request at a falling edge and holds it until the ready pulse, and it loads every configuration word while the bus is idle. The next request follows immediately after each ready pulse, so the turnaround counts it measures are exact values and not merely lower bounds.

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl #(
  parameter int AW = 24,
  parameter int BANK_LSB = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cfg_we,
  input  logic [18:0]   cfg_wdata,
  input  logic [3:0]    err_clr,
  output logic [3:0]    prot_err,
  output logic [3:0]    size_err,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic [3:0]    req_be,
  input  logic [31:0]   req_wdata,
  output logic          req_ready,
  output logic          req_err,
  output logic [31:0]   req_rdata,
  output logic [3:0]    mem_cs_n,
  output logic [3:0]    mem_bls_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_dout,
  output logic          mem_doe,
  input  logic [31:0]   mem_din
);
  localparam logic [18:0] CFG_RST = {2'b10, 3'b000, 5'h1F, 5'h1F, 4'hF};

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSET, S_WSTB, S_WHLD} st_t;

  st_t           st;
  logic [18:0]   cfg [4];
  logic [5:0]    cnt;
  logic [4:0]    gap;
  logic [1:0]    bank_q, last_bank;
  logic [AW-1:0] addr_q, last_addr, step;
  logic [31:0]   wdata_q, rdata_q;
  logic [3:0]    be_q;
  logic          ready_q, err_q, last_ok, last_wr, seq_ok;

  wire [1:0] rb       = req_addr[BANK_LSB+1:BANK_LSB];
  wire       take     = (st == S_IDLE) && req_valid && !ready_q;
  wire       size_hit = take && (req_size > 3'd2);
  wire       prot_hit = take && !size_hit && req_write && cfg[rb][15];
  wire       turn     = last_ok && (rb != last_bank || req_write != last_wr);
  wire       go       = take && !size_hit && !prot_hit &&
                        (!turn || gap >= {1'b0, cfg[rb][3:0]});

  always_comb
    case (cfg[rb][18:17])
      2'b00:   step = AW'(1);
      2'b01:   step = AW'(2);
      default: step = AW'(4);
    endcase

  wire seq = seq_ok && !req_write && rb == last_bank && cfg[rb][16] &&
             req_addr == last_addr + step;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) cfg[i] <= CFG_RST;
    end else begin
      for (int i = 0; i < 4; i++) if (cfg_we[i]) cfg[i] <= cfg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prot_err <= '0;
      size_err <= '0;
    end else begin
      prot_err <= (prot_err & ~err_clr) | (prot_hit ? 4'b1 << rb : 4'b0);
      size_err <= (size_err & ~err_clr) | (size_hit ? 4'b1 << rb : 4'b0);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      gap <= '1;
      bank_q <= '0;
      addr_q <= '0;
      wdata_q <= '0;
      be_q <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
      err_q <= 1'b0;
      last_ok <= 1'b0;
      last_wr <= 1'b0;
      last_bank <= '0;
      last_addr <= '0;
      seq_ok <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      err_q <= 1'b0;
      if (st != S_IDLE) gap <= '0;
      else if (gap != 5'h1F) gap <= gap + 5'd1;
      case (st)
        S_IDLE: begin
          if (size_hit || prot_hit) begin
            ready_q <= 1'b1;
            err_q <= 1'b1;
            seq_ok <= 1'b0;
          end else if (go) begin
            bank_q <= rb;
            addr_q <= req_addr;
            wdata_q <= req_wdata;
            be_q <= req_be;
            if (req_write) st <= S_WSET;
            else begin
              st <= S_RD;
              cnt <= seq ? {1'b0, cfg[rb][13:9]} : {1'b0, cfg[rb][8:4]} + 6'd2;
            end
          end
        end
        S_RD:
          if (cnt == '0) begin
            rdata_q <= mem_din;
            ready_q <= 1'b1;
            st <= S_IDLE;
            last_ok <= 1'b1;
            last_wr <= 1'b0;
            last_bank <= bank_q;
            last_addr <= addr_q;
            seq_ok <= 1'b1;
          end else cnt <= cnt - 6'd1;
        S_WSET: begin
          cnt <= {1'b0, cfg[bank_q][13:9]};
          st <= S_WSTB;
        end
        S_WSTB:
          if (cnt == '0) st <= S_WHLD;
          else cnt <= cnt - 6'd1;
        S_WHLD: begin
          ready_q <= 1'b1;
          st <= S_IDLE;
          last_ok <= 1'b1;
          last_wr <= 1'b1;
          last_bank <= bank_q;
          last_addr <= addr_q;
          seq_ok <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end

  wire cs_on = (st == S_RD) || (st == S_WSTB) || (st == S_WHLD);

  assign req_ready = ready_q;
  assign req_err   = err_q;
  assign req_rdata = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_dout  = wdata_q;
  assign mem_cs_n  = cs_on ? ~(4'b1 << bank_q) : 4'hF;
  assign mem_we_n  = (st != S_WSTB);
  assign mem_doe   = (st == S_WSET) || (st == S_WSTB) || (st == S_WHLD);
  assign mem_bls_n = (st == S_WSTB) ? ~be_q :
                     (st == S_RD && cfg[bank_q][14]) ? 4'h0 : 4'hF;
endmodule

module smc_bank_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mem_cs_n,
  input logic       mem_we_n,
  input logic       mem_doe,
  input logic       req_ready,
  input logic       req_err,
  input logic [3:0] prot_err,
  input logic [3:0] size_err,
  input logic [3:0] err_clr
);
  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~mem_cs_n)); // R1
  AST_STROBE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (mem_cs_n != 4'hF && mem_doe)); // R3
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |=> !req_ready); // R10
  AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n) req_err |-> req_ready); // R7
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n) req_err |-> (mem_cs_n == 4'hF && !mem_doe)); // R8
  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (err_clr == 4'h0) |=> ($past(prot_err) & ~prot_err) == 4'h0); // R7
  AST_SIZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (err_clr == 4'h0) |=> ($past(size_err) & ~size_err) == 4'h0); // R8
endmodule

bind smc_bank_ctrl smc_bank_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_doe(mem_doe), .req_ready(req_ready), .req_err(req_err),
  .prot_err(prot_err), .size_err(size_err), .err_clr(err_clr)
);

// File: tb/tb_smc_bank_ctrl.sv
module tb_smc_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int NV = 14;

  // wr | bank | off | size | be | err | cs cycles | we cycles | gap (0 = skip)
  localparam logic [42:0] VECS [NV] = '{
    {1'b0, 2'd0, 8'h00, 3'd2, 4'hF, 1'b0, 8'd5,  8'd0,  8'd0},
    {1'b0, 2'd0, 8'h04, 3'd2, 4'hF, 1'b0, 8'd5,  8'd0,  8'd2},
    {1'b1, 2'd0, 8'h08, 3'd2, 4'hF, 1'b0, 8'd3,  8'd2,  8'd2},
    {1'b0, 2'd1, 8'h00, 3'd1, 4'hF, 1'b0, 8'd3,  8'd0,  8'd4},
    {1'b0, 2'd1, 8'h02, 3'd1, 4'hF, 1'b0, 8'd4,  8'd0,  8'd2},
    {1'b0, 2'd1, 8'h06, 3'd1, 4'hF, 1'b0, 8'd3,  8'd0,  8'd2},
    {1'b1, 2'd2, 8'h00, 3'd2, 4'hF, 1'b1, 8'd0,  8'd0,  8'd0},
    {1'b0, 2'd2, 8'h00, 3'd2, 4'hF, 1'b0, 8'd7,  8'd0,  8'd0},
    {1'b0, 2'd0, 8'h00, 3'd3, 4'hF, 1'b1, 8'd0,  8'd0,  8'd0},
    {1'b1, 2'd1, 8'h10, 3'd1, 4'h3, 1'b0, 8'd5,  8'd4,  8'd0},
    {1'b0, 2'd1, 8'h12, 3'd1, 4'hF, 1'b0, 8'd3,  8'd0,  8'd4},
    {1'b0, 2'd1, 8'h14, 3'd1, 4'hF, 1'b0, 8'd4,  8'd0,  8'd2},
    {1'b1, 2'd3, 8'h00, 3'd2, 4'h5, 1'b0, 8'd33, 8'd32, 8'd16},
    {1'b0, 2'd3, 8'h00, 3'd2, 4'hF, 1'b0, 8'd34, 8'd0,  8'd16}
  };

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [3:0]    cfg_we = '0, err_clr = '0;
  logic [18:0]   cfg_wdata = '0;
  logic [3:0]    prot_err, size_err;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_size = '0;
  logic [3:0]    req_be = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, req_err;
  logic [31:0]   req_rdata;
  logic [3:0]    mem_cs_n, mem_bls_n;
  logic          mem_we_n, mem_doe;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_dout, mem_din;

  int errors = 0, checks = 0;
  int idle_run = 0, last_gap = -1;
  logic was_act = 1'b0;

  assign mem_din = {8'h5A, mem_addr};

  smc_bank_ctrl #(.AW(AW), .BANK_LSB(22)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .err_clr(err_clr), .prot_err(prot_err), .size_err(size_err),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_be(req_be), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_err(req_err), .req_rdata(req_rdata),
    .mem_cs_n(mem_cs_n), .mem_bls_n(mem_bls_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic act;
    @(negedge clk);
    act = (mem_cs_n != 4'hF) || mem_doe;
    if (act) begin
      if (!was_act) last_gap = idle_run;
      idle_run = 0;
    end else idle_run++;
    was_act = act;
  endtask

  function automatic logic [18:0] mkcfg(input logic [1:0] w, input logic b, p, l,
                                        input logic [4:0] ww, rw, input logic [3:0] id);
    return {w, b, p, l, ww, rw, id};
  endfunction

  task automatic run_vec(input int idx);
    logic [42:0] v;
    logic [1:0] bk;
    int cs_cnt, we_cnt, oth, bls_bad, dout_bad, lat;
    logic [3:0] rd_bls;
    v = VECS[idx];
    bk = v[41:40];
    rd_bls = (bk == 2'd1) ? 4'h0 : 4'hF;
    cs_cnt = 0; we_cnt = 0; oth = 0; bls_bad = 0; dout_bad = 0; lat = 0;
    last_gap = -1;
    req_valid = 1'b1;
    req_write = v[42];
    req_addr = {bk, 14'd0, v[39:32]};
    req_size = v[31:29];
    req_be = v[28:25];
    req_wdata = 32'hC0DE0000 | idx;
    do begin
      tick();
      lat++;
      if (!mem_cs_n[bk]) cs_cnt++;
      if ((~mem_cs_n & ~(4'b1 << bk)) != 4'h0) oth++;
      if (!mem_we_n) begin
        we_cnt++;
        if (mem_bls_n != ~v[28:25]) bls_bad++;
      end else if (v[42] && mem_doe && mem_bls_n != 4'hF) bls_bad++;
      if (mem_doe && mem_dout != req_wdata) dout_bad++;
      if (!v[42] && !mem_cs_n[bk] && mem_bls_n != rd_bls) bls_bad++;
    end while (!req_ready && lat < 2000);
    req_valid = 1'b0;
    check("R10 ready seen", lat < 2000, 1);
    check(v[24] ? "R7/R8 error response" : "R10 no error", req_err, v[24]);
    check(v[42] ? "R3 write cs cycles" : "R2/R4 read cs cycles", cs_cnt, v[23:16]);
    check("R3 strobe cycles", we_cnt, v[15:8]);
    check("R1 other bank selected", oth, 0);
    check("R3/R6 byte lanes", bls_bad, 0);
    if (v[42]) check("R3 write data", dout_bad, 0);
    if (!v[42] && !v[24]) check("R2 read data", req_rdata, {8'h5A, req_addr});
    if (v[7:0] != 0) check("R5 turnaround gap", last_gap, v[7:0]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R9 reset cs", mem_cs_n, 4'hF);
    check("R9 reset we", mem_we_n, 1);
    check("R9 reset doe", mem_doe, 0);
    check("R9 reset ready", req_ready, 0);
    check("R9 reset prot flags", prot_err, 0);
    check("R9 reset size flags", size_err, 0);

    cfg_wdata = mkcfg(2'b10, 1'b0, 1'b0, 1'b0, 5'd1, 5'd2, 4'd1); cfg_we = 4'b0001; tick();
    cfg_wdata = mkcfg(2'b01, 1'b1, 1'b0, 1'b1, 5'd3, 5'd0, 4'd3); cfg_we = 4'b0010; tick();
    cfg_wdata = mkcfg(2'b10, 1'b0, 1'b1, 1'b0, 5'd0, 5'd4, 4'd0); cfg_we = 4'b0100; tick();
    cfg_we = 4'b0000;
    repeat (4) tick();

    for (int i = 0; i < NV; i++) run_vec(i);

    tick();
    check("R7 protect flag set", prot_err, 4'b0100);
    check("R8 size flag set", size_err, 4'b0001);
    err_clr = 4'b0100; tick(); err_clr = 4'b0000; tick();
    check("R7 protect flag cleared", prot_err, 4'b0000);
    check("R8 size flag kept", size_err, 4'b0001);
    err_clr = 4'b0001; tick(); err_clr = 4'b0000; tick();
    check("R8 size flag cleared", size_err, 4'b0000);

    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h000040; req_size = 3'd2;
    do tick(); while (!req_ready);
    tick();
    check("R10 ready one cycle", req_ready, 0);
    check("R10 no re-accept", mem_cs_n, 4'hF);
    req_valid = 1'b0;
    repeat (8) tick();
    check("R10 held request not repeated", mem_cs_n, 4'hF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule